// File: doc/BRIEF.md
# Interconnect Test Vector Generator

This block supplies parallel stimulus for testing a group of board nets through a boundary-scan chain. Each output vector holds one bit per net, and all of its bits are applied to the nets together in one step. The block can produce two kinds of sequence:

- **Counting.** Net *j* (port bit *j*) is given the number *j+1*. The sequence has ceil(log2(N+2)) vectors. Because of this numbering, no net ever sees a constant code across the whole sequence. That means a net stuck at 0 or stuck at 1 is caught in the same pass as a short between nets.
- **Walking.** A single active bit moves across the nets, one net per step. The active bit is a 1, or a 0 when the inverted variant is chosen.

Each vector is offered with a valid/ready handshake. Once a vector is accepted, the block waits for the response captured from the nets. The response is compared bit by bit with the vector that was applied. Every net that differs is added to a sticky fault mask. The number of differing bits is added to a running error count.

The sequence is chosen when it starts, and no new start is accepted until it ends. The final vector carries a last flag. After the response to that vector arrives, the block returns to idle, with the mask and the count left readable.

Top module: `ivg_top`

## Requirements
- R1: With `algo_walk_i`=0, the sequence has ceil(log2(N_NETS+2)) vectors (3 for N_NETS=6). In vector k (k from 0), bit j of `vec_o` equals bit k of the number j+1.
- R2: With `algo_walk_i`=1 and `invert_i`=0, the sequence has exactly N_NETS vectors. Vector k has only bit k set.
- R3: With `algo_walk_i`=1 and `invert_i`=1, each vector is the bitwise complement of the matching walking-one vector. In counting mode, `invert_i` has no effect.
- R4: A vector stays valid and unchanged while `vec_ready_i` is low. After a vector is accepted, no vector is offered until a response has been taken.
- R5: `vec_last_o` is high only together with the final valid vector of a sequence. After the response to that vector, `busy_o` falls and `vec_valid_o` stays low.
- R6: Each response bit that differs from the applied vector sets the matching bit of `fault_mask_o`. The mask bits stay set until the next accepted start, which clears them.
- R7: `err_count_o` grows by the number of differing bits in each response. It is cleared by an accepted start.
- R8: A start request while `busy_o` is high is ignored. The mode in use is the one sampled at the accepted start.
- R9: After reset, `busy_o`, `vec_valid_o`, `vec_last_o`, `fault_mask_o` and `err_count_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a sequence |
| algo_walk_i | input | 1 | 0 = counting, 1 = walking, sampled at start |
| invert_i | input | 1 | In walking mode, 1 = walking zero, sampled at start |
| vec_valid_o | output | 1 | Stimulus vector available |
| vec_ready_i | input | 1 | Consumer accepts the vector |
| vec_o | output | N_NETS | Stimulus vector, bit j drives net j |
| vec_last_o | output | 1 | Current vector is the final one |
| resp_valid_i | input | 1 | Captured response present |
| resp_i | input | N_NETS | Captured net values |
| busy_o | output | 1 | Sequence in progress |
| fault_mask_o | output | N_NETS | Sticky per-net mismatch flags |
| err_count_o | output | ERR_W | Total mismatching bits since start |

## Verification
The assertions assume the following about the block's inputs:
- A response arrives only after its vector has been accepted.
- The consumer does not expect `vec_o` to change until it raises ready.

The stimulus keeps within these assumptions. It raises `resp_valid_i` only in the cycle after a handshake, and it pulses start for a single cycle, either while idle or deliberately in the middle of a sequence. Under these conditions, the properties check the following:
- The vector is held while ready is low.
- The walking-one vector stays one-hot.
- The mask only gains bits during a sequence.
- A sequence starts from a clean mask and count.
- Idle is re-entered only on a response.

// File: rtl/ivg_pkg.sv
`timescale 1ns/1ps
package ivg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } ivg_state_e;
endpackage

// File: rtl/ivg_pattern.sv
`timescale 1ns/1ps
module ivg_pattern #(
    parameter int N_NETS = 6,
    parameter int STEP_W = 3
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic              walk_i,
    input  logic              inv_i,
    output logic [N_NETS-1:0] vec_o
);
    localparam int CODE_W = $clog2(N_NETS + 2);

    for (genvar j = 0; j < N_NETS; j++) begin : g_net
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] shifted;
        logic              walk_bit;
        assign code     = CODE_W'(j + 1);
        assign shifted  = code >> step_i;
        assign walk_bit = (step_i == STEP_W'(j));
        assign vec_o[j] = walk_i ? (walk_bit ^ inv_i) : shifted[0];
    end
endmodule

// File: rtl/ivg_compare.sv
`timescale 1ns/1ps
module ivg_compare #(
    parameter int N_NETS = 6,
    parameter int ERR_W  = 6
) (
    input  logic [N_NETS-1:0] applied_i,
    input  logic [N_NETS-1:0] resp_i,
    output logic [N_NETS-1:0] diff_o,
    output logic [ERR_W-1:0]  ones_o
);
    assign diff_o = applied_i ^ resp_i;

    always_comb begin
        ones_o = '0;
        for (int i = 0; i < N_NETS; i++) begin
            ones_o = ones_o + ERR_W'(diff_o[i]);
        end
    end
endmodule

// File: rtl/ivg_top.sv
`timescale 1ns/1ps
module ivg_top #(
    parameter int N_NETS = 6,
    localparam int CNT_VECS = $clog2(N_NETS + 2),
    localparam int MAX_VECS = (N_NETS > CNT_VECS) ? N_NETS : CNT_VECS,
    localparam int STEP_W   = $clog2(MAX_VECS + 1),
    localparam int ERR_W    = $clog2(N_NETS * MAX_VECS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              algo_walk_i,
    input  logic              invert_i,
    output logic              vec_valid_o,
    input  logic              vec_ready_i,
    output logic [N_NETS-1:0] vec_o,
    output logic              vec_last_o,
    input  logic              resp_valid_i,
    input  logic [N_NETS-1:0] resp_i,
    output logic              busy_o,
    output logic [N_NETS-1:0] fault_mask_o,
    output logic [ERR_W-1:0]  err_count_o
);
    import ivg_pkg::*;

    typedef struct packed {
        ivg_state_e        st;
        logic              walk;
        logic              inv;
        logic [STEP_W-1:0] step;
        logic [N_NETS-1:0] mask;
        logic [ERR_W-1:0]  errs;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [N_NETS-1:0] cur_vec;
    logic [N_NETS-1:0] diff;
    logic [ERR_W-1:0]  diff_ones;
    logic [STEP_W-1:0] last_idx;
    logic              at_last;
    logic              walk_q, inv_q;

    ivg_pattern #(.N_NETS(N_NETS), .STEP_W(STEP_W)) u_pattern (
        .step_i (regs_q.step),
        .walk_i (regs_q.walk),
        .inv_i  (regs_q.inv),
        .vec_o  (cur_vec)
    );

    ivg_compare #(.N_NETS(N_NETS), .ERR_W(ERR_W)) u_compare (
        .applied_i (cur_vec),
        .resp_i    (resp_i),
        .diff_o    (diff),
        .ones_o    (diff_ones)
    );

    assign last_idx = regs_q.walk ? STEP_W'(N_NETS - 1) : STEP_W'(CNT_VECS - 1);
    assign at_last  = (regs_q.step == last_idx);

    always_comb begin
        regs_d = regs_q;
        case (regs_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    regs_d.st   = ST_SEND;
                    regs_d.walk = algo_walk_i;
                    regs_d.inv  = algo_walk_i & invert_i;
                    regs_d.step = '0;
                    regs_d.mask = '0;
                    regs_d.errs = '0;
                end
            end
            ST_SEND: begin
                if (vec_ready_i) begin
                    regs_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (resp_valid_i) begin
                    regs_d.mask = regs_q.mask | diff;
                    regs_d.errs = regs_q.errs + diff_ones;
                    if (at_last) begin
                        regs_d.st = ST_IDLE;
                    end else begin
                        regs_d.st   = ST_SEND;
                        regs_d.step = regs_q.step + STEP_W'(1);
                    end
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_IDLE, walk: 1'b0, inv: 1'b0, step: '0, mask: '0, errs: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign vec_valid_o  = (regs_q.st == ST_SEND);
    assign vec_o        = cur_vec;
    assign vec_last_o   = vec_valid_o & at_last;
    assign busy_o       = (regs_q.st != ST_IDLE);
    assign fault_mask_o = regs_q.mask;
    assign err_count_o  = regs_q.errs;
    assign walk_q       = regs_q.walk;
    assign inv_q        = regs_q.inv;
endmodule

// File: rtl/ivg_checker.sv
`timescale 1ns/1ps
module ivg_checker #(
    parameter int N_NETS = 6,
    parameter int ERR_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              vec_valid_o,
    input logic              vec_ready_i,
    input logic [N_NETS-1:0] vec_o,
    input logic              vec_last_o,
    input logic              resp_valid_i,
    input logic              busy_o,
    input logic [N_NETS-1:0] fault_mask_o,
    input logic [ERR_W-1:0]  err_count_o,
    input logic              walk_q,
    input logic              inv_q
);
    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o && !vec_ready_i |=> vec_valid_o && $stable(vec_o)); // R4

    AST_NO_OFFER_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o && vec_ready_i |=> !vec_valid_o); // R4

    AST_WALK_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o && walk_q && !inv_q |-> $onehot(vec_o)); // R2

    AST_WALK_ZERO_COLD: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o && walk_q && inv_q |-> $onehot(~vec_o)); // R3

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        vec_last_o |-> vec_valid_o); // R5

    AST_IDLE_ON_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(resp_valid_i)); // R5

    AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) |-> ((fault_mask_o & $past(fault_mask_o)) == $past(fault_mask_o))); // R6

    AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (fault_mask_o == '0) && (err_count_o == '0)); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && busy_o |=> (walk_q == $past(walk_q)) && (inv_q == $past(inv_q))); // R8
endmodule

bind ivg_top ivg_checker #(.N_NETS(N_NETS), .ERR_W(ERR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .vec_valid_o  (vec_valid_o),
    .vec_ready_i  (vec_ready_i),
    .vec_o        (vec_o),
    .vec_last_o   (vec_last_o),
    .resp_valid_i (resp_valid_i),
    .busy_o       (busy_o),
    .fault_mask_o (fault_mask_o),
    .err_count_o  (err_count_o),
    .walk_q       (walk_q),
    .inv_q        (inv_q)
);

// File: tb/tb_ivg_top.sv
`timescale 1ns/1ps
module tb_ivg_top;
    localparam int N = 6;
    localparam int EW = 6;

    typedef struct packed {
        logic       walk;
        logic       inv;
        logic [5:0] vec;
        logic [5:0] resp;
        logic       last;
    } row_t;

    // counting (R1), walking one (R2), walking zero (R3); faults injected in resp
    localparam row_t TBL [15] = '{
        '{1'b0, 1'b0, 6'h15, 6'h15, 1'b0},
        '{1'b0, 1'b0, 6'h26, 6'h26, 1'b0},
        '{1'b0, 1'b0, 6'h38, 6'h38, 1'b1},
        '{1'b1, 1'b0, 6'h01, 6'h01, 1'b0},
        '{1'b1, 1'b0, 6'h02, 6'h02, 1'b0},
        '{1'b1, 1'b0, 6'h04, 6'h06, 1'b0},
        '{1'b1, 1'b0, 6'h08, 6'h08, 1'b0},
        '{1'b1, 1'b0, 6'h10, 6'h10, 1'b0},
        '{1'b1, 1'b0, 6'h20, 6'h20, 1'b1},
        '{1'b1, 1'b1, 6'h3E, 6'h3F, 1'b0},
        '{1'b1, 1'b1, 6'h3D, 6'h3D, 1'b0},
        '{1'b1, 1'b1, 6'h3B, 6'h3B, 1'b0},
        '{1'b1, 1'b1, 6'h37, 6'h37, 1'b0},
        '{1'b1, 1'b1, 6'h2F, 6'h0F, 1'b0},
        '{1'b1, 1'b1, 6'h1F, 6'h1F, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          algo_walk_i = 1'b0;
    logic          invert_i = 1'b0;
    logic          vec_valid_o;
    logic          vec_ready_i = 1'b0;
    logic [N-1:0]  vec_o;
    logic          vec_last_o;
    logic          resp_valid_i = 1'b0;
    logic [N-1:0]  resp_i = '0;
    logic          busy_o;
    logic [N-1:0]  fault_mask_o;
    logic [EW-1:0] err_count_o;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] exp_mask;
    int           exp_cnt;

    always #4 clk = ~clk;

    ivg_top #(.N_NETS(N)) dut (.*);

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic start_seq(input logic walk, input logic inv);
        @(negedge clk);
        start_i = 1'b1; algo_walk_i = walk; invert_i = inv;
        @(negedge clk);
        start_i = 1'b0;
        exp_mask = '0; exp_cnt = 0;
    endtask

    task automatic wait_valid(input string tag);
        int n = 0;
        while (!vec_valid_o && n < 20) begin
            @(negedge clk);
            n++;
        end
        check({tag, " vec_valid"}, int'(vec_valid_o), 1);
    endtask

    task automatic do_step(input string tag, input logic [N-1:0] ev, input logic [N-1:0] rv,
                           input logic el);
        wait_valid(tag);
        check({tag, " vec"}, int'(vec_o), int'(ev));
        check({tag, " last R5"}, int'(vec_last_o), int'(el));
        vec_ready_i = 1'b1;
        @(negedge clk);
        vec_ready_i = 1'b0;
        check({tag, " no offer while waiting R4"}, int'(vec_valid_o), 0);
        resp_i = rv; resp_valid_i = 1'b1;
        @(negedge clk);
        resp_valid_i = 1'b0;
        exp_mask = exp_mask | (ev ^ rv);
        exp_cnt  = exp_cnt + $countones(ev ^ rv);
    endtask

    task automatic check_end(input string tag);
        check({tag, " mask R6"}, int'(fault_mask_o), int'(exp_mask));
        check({tag, " count R7"}, int'(err_count_o), exp_cnt);
        check({tag, " idle R5"}, int'(busy_o), 0);
        check({tag, " quiet R5"}, int'(vec_valid_o), 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_mask = '0; exp_cnt = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 busy", int'(busy_o), 0);
        check("R9 valid", int'(vec_valid_o), 0);
        check("R9 last", int'(vec_last_o), 0);
        check("R9 mask", int'(fault_mask_o), 0);
        check("R9 count", int'(err_count_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 15; i++) begin
            if (i == 0 || TBL[i-1].last) start_seq(TBL[i].walk, TBL[i].inv);
            do_step($sformatf("R1/R2/R3 row %0d", i), TBL[i].vec, TBL[i].resp, TBL[i].last);
            if (TBL[i].last) check_end($sformatf("row %0d", i));
        end

        // R3: invert has no effect in counting mode; R4 hold; R8 start ignored
        start_seq(1'b0, 1'b1);
        check("R6 cleared on start mask", int'(fault_mask_o), 0);
        check("R7 cleared on start count", int'(err_count_o), 0);
        check("R3 invert ignored in counting", int'(vec_o), 'h15);
        repeat (3) @(negedge clk);
        check("R4 held valid", int'(vec_valid_o), 1);
        check("R4 held vec", int'(vec_o), 'h15);
        start_i = 1'b1; algo_walk_i = 1'b1; invert_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 start ignored vec", int'(vec_o), 'h15);
        check("R8 still busy", int'(busy_o), 1);
        // all-zero responses model stuck-at-0 on every net (R1 codes avoid all-zero)
        do_step("R8 count s0", 6'h15, 6'h00, 1'b0);
        do_step("R1 count s1", 6'h26, 6'h00, 1'b0);
        check("R6 sticky mid-sequence", int'(fault_mask_o), 'h37);
        do_step("R1 count s2", 6'h38, 6'h00, 1'b1);
        check("R6 stuck-at mask", int'(fault_mask_o), 'h3F);
        check("R7 stuck-at count", int'(err_count_o), 9);
        check_end("stuck-at");

        // R6/R7: new start clears, clean walking-one run leaves mask empty
        start_seq(1'b1, 1'b0);
        check("R6 clear on restart", int'(fault_mask_o), 0);
        check("R7 clear on restart", int'(err_count_o), 0);
        for (int k = 0; k < N; k++) begin
            do_step($sformatf("R2 clean %0d", k), 6'(1 << k), 6'(1 << k), k == N - 1);
        end
        check_end("clean walk");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule